// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block turns host register accesses into byte-wide handshake cycles on the peripheral side of an enhanced parallel port. An access to offset 3 runs an address cycle. An access to offset 4 runs a data cycle. A data access may be 1, 2 or 4 bytes wide and is broken into single-byte cycles, lowest byte first. The host supplies the current port control value with every access. A cycle starts only when the direction bit and the four signal bits of that value match the pattern required for the transfer direction. If they do not match, nothing happens on the peripheral bus.

Each byte cycle follows the same sequence. The block sets the write-direction line first. It then raises the matching strobe and waits for the peripheral's wait line to go high. After that it drops the strobe and waits for the wait line to fall. If either wait phase runs longer than a parameterised number of clocks, the transfer is cut short and a sticky timeout flag is set. The host reads this flag in bit 0 of the status word at offset 1, and clears it by writing that bit as 1. A busy output tells the host when it may issue a new access. A one-cycle done pulse ends every accepted access and presents any read data.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: A write to offset 3 or 4 starts peripheral cycles only when (ctrl & 0x2F) == 0x04. Upper control bits are ignored. With any other value the write causes no strobe, and it still ends with a done pulse.
- R2: A read from offset 3 or 4 starts peripheral cycles only when (ctrl & 0x2F) == 0x24. Otherwise no strobe occurs, and the read returns ones in every byte lane of the access width and zeros above it.
- R3: Offset 3 uses the address strobe and offset 4 uses the data strobe. The two strobes are never high together. The direction line (1 = write) is set one clock before the strobe rises. The strobe stays high until the wait line is seen high. The cycle then ends only after the wait line is seen low.
- R4: The size encoding 0, 1 and 2 or 3 selects 1, 2 or 4 bytes at offset 4. Offset 3 always transfers one byte. Byte 0 (bits 7:0) goes first, and the byte on the data lines is stable while the strobe is high. Read bytes are placed little-endian.
- R5: If the wait line does not change within TIMEOUT_CLKS clocks in either phase, the strobe is released, the remaining bytes are skipped, the access ends with done, and the timeout flag is set.
- R6: The timeout flag stays set until a status write (offset 1) with bit 0 = 1. A status write with bit 0 = 0 leaves it unchanged.
- R7: A status read returns {status_in[7:1], timeout flag} in bits 7:0, with zeros above.
- R8: Reset clears the timeout flag, the strobes, the direction line, busy and done.
- R9: Busy goes high the clock after an access is accepted and stays high through the done pulse. Requests made while busy are ignored. Done lasts exactly one clock.
- R10: On a read cut short by a timeout, each byte lane that received no byte reads as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, accepted when busy is low |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset (1 status, 3 address cycle, 4 data cycle) |
| host_size | input | 2 | Data width code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| host_wdata | input | DATA_W | Write data, little-endian |
| ctrl | input | 8 | Current port control register value |
| status_in | input | 8 | Peripheral status lines, bit 0 replaced by the flag |
| host_rdata | output | DATA_W | Read data, valid with host_done |
| host_done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Access in progress |
| pp_dout | output | 8 | Byte driven toward the peripheral |
| pp_din | input | 8 | Byte returned by the peripheral |
| pp_write | output | 1 | Direction line, 1 = host writes |
| pp_astb | output | 1 | Address strobe, active high |
| pp_dstb | output | 1 | Data strobe, active high |
| pp_wait | input | 1 | Peripheral wait/acknowledge line |

## Verification
The hardest cases to reach are the aborts in the middle of a transfer. One is a wait line that never rises, so the abort happens in the strobe phase. The other is a wait line that rises but never falls, so the abort happens in the release phase. In both cases the rest of a 4-byte access must be dropped. The bench's peripheral model has a normal mode and one mode for each of these failures. It counts every strobe rise, so the number of bytes actually transferred can be compared with the number requested. A further case sends a status-clear request while a slow transfer holds busy high, and then shows through a status read that the flag survived.

// File: rtl/epp_pkg.sv
package epp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE,
        ST_DONE
    } epp_state_e;

    localparam logic [7:0] CTRL_MASK  = 8'h2F;
    localparam logic [7:0] CTRL_WR_OK = 8'h04;
    localparam logic [7:0] CTRL_RD_OK = 8'h24;

    localparam logic [2:0] OFS_STATUS = 3'd1;
    localparam logic [2:0] OFS_ADDR   = 3'd3;
    localparam logic [2:0] OFS_DATA   = 3'd4;
endpackage

// File: rtl/epp_access_gate.sv
module epp_access_gate
    import epp_pkg::*;
(
    input  logic [7:0] ctrl,
    input  logic       is_wr,
    output logic       allowed
);
    logic [7:0] want;

    always_comb begin
        want    = is_wr ? CTRL_WR_OK : CTRL_RD_OK;
        allowed = ((ctrl & CTRL_MASK) == want);
    end
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        expired = run && (cnt_q == LAST);
        if (clr) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/epp_byte_lane.sv
module epp_byte_lane #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic [DATA_W-1:0] wword,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        rbyte,
    input  logic [DATA_W-1:0] rword,
    output logic [7:0]        wbyte,
    output logic [DATA_W-1:0] rmerged
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0][7:0] wl;

    assign wl    = wword;
    assign wbyte = wl[idx];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rmerged[g*8 +: 8] = (idx == IDX_W'(g)) ? rbyte : rword[g*8 +: 8];
    end
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
    import epp_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int TIMEOUT_CLKS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [1:0]        host_size,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [7:0]        ctrl,
    input  logic [7:0]        status_in,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic              busy,
    output logic [7:0]        pp_dout,
    input  logic [7:0]        pp_din,
    output logic              pp_write,
    output logic              pp_astb,
    output logic              pp_dstb,
    input  logic              pp_wait
);
    localparam int NBYTES = DATA_W / 8;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        epp_state_e        state;
        logic              is_wr;
        logic              is_addr;
        logic [IDX_W-1:0]  last_idx;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              flag;
    } regs_t;

    regs_t q, d;

    logic              allowed;
    logic              tmr_clr, tmr_run, tmr_exp;
    logic [7:0]        cur_byte;
    logic [DATA_W-1:0] merged;
    logic [IDX_W-1:0]  req_last;
    logic [DATA_W-1:0] width_ones;
    logic              tmo_flag;

    epp_access_gate i_gate (
        .ctrl    (ctrl),
        .is_wr   (host_wr),
        .allowed (allowed)
    );

    epp_wait_timer #(.LIMIT(TIMEOUT_CLKS)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    epp_byte_lane #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_lane (
        .wword   (q.wdata),
        .idx     (q.idx),
        .rbyte   (pp_din),
        .rword   (q.rdata),
        .wbyte   (cur_byte),
        .rmerged (merged)
    );

    // last byte index of the requested access, clipped to the bus width
    always_comb begin
        int nb;
        if (host_addr == OFS_ADDR) nb = 1;
        else                       nb = 1 << ((host_size == 2'd3) ? 2 : int'(host_size));
        if (nb > NBYTES) nb = NBYTES;
        req_last = IDX_W'(nb - 1);
        for (int i = 0; i < NBYTES; i++) begin
            width_ones[i*8 +: 8] = (i < nb) ? 8'hFF : 8'h00;
        end
    end

    always_comb begin
        d       = q;
        tmr_clr = 1'b0;
        tmr_run = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (host_req) begin
                    d.state = ST_DONE;
                    d.is_wr = host_wr;
                    d.idx   = '0;
                    if (host_addr == OFS_STATUS) begin
                        if (host_wr) begin
                            d.rdata = '0;
                            if (host_wdata[0]) d.flag = 1'b0;
                        end else begin
                            d.rdata = DATA_W'({status_in[7:1], q.flag});
                        end
                    end else if (host_addr == OFS_ADDR || host_addr == OFS_DATA) begin
                        d.is_addr  = (host_addr == OFS_ADDR);
                        d.last_idx = req_last;
                        d.wdata    = host_wdata;
                        d.rdata    = host_wr ? '0 : width_ones;
                        if (allowed) d.state = ST_SETUP;
                    end else begin
                        d.rdata = host_wr ? '0 : DATA_W'(8'hFF);
                    end
                end
            end
            ST_SETUP: begin
                tmr_clr = 1'b1;
                d.state = ST_STROBE;
            end
            ST_STROBE: begin
                if (pp_wait) begin
                    tmr_clr = 1'b1;
                    if (!q.is_wr) d.rdata = merged;
                    d.state = ST_RELEASE;
                end else begin
                    tmr_run = 1'b1;
                    if (tmr_exp) begin
                        d.flag  = 1'b1;
                        d.state = ST_DONE;
                    end
                end
            end
            ST_RELEASE: begin
                if (!pp_wait) begin
                    if (q.idx == q.last_idx) begin
                        d.state = ST_DONE;
                    end else begin
                        d.idx   = q.idx + 1'b1;
                        d.state = ST_SETUP;
                    end
                end else begin
                    tmr_run = 1'b1;
                    if (tmr_exp) begin
                        d.flag  = 1'b1;
                        d.state = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    logic in_cycle;
    assign in_cycle   = (q.state == ST_SETUP) || (q.state == ST_STROBE) || (q.state == ST_RELEASE);
    assign pp_write   = in_cycle && q.is_wr;
    assign pp_dout    = pp_write ? cur_byte : 8'h00;
    assign pp_astb    = (q.state == ST_STROBE) && q.is_addr;
    assign pp_dstb    = (q.state == ST_STROBE) && !q.is_addr;
    assign busy       = (q.state != ST_IDLE);
    assign host_done  = (q.state == ST_DONE);
    assign host_rdata = q.rdata;
    assign tmo_flag   = q.flag;
endmodule

// File: rtl/epp_cycle_checker.sv
module epp_cycle_checker #(
    parameter int DATA_W = 32,
    parameter int LIMIT  = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_wr,
    input logic [2:0]        host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              busy,
    input logic              host_done,
    input logic              pp_astb,
    input logic              pp_dstb,
    input logic              pp_write,
    input logic [7:0]        pp_dout,
    input logic              flag
);
    logic        strb;
    logic        clear_req;
    logic [31:0] strb_run;

    assign strb      = pp_astb || pp_dstb;
    assign clear_req = host_req && !busy && host_wr && (host_addr == 3'd1) && host_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    strb_run <= '0;
        else if (strb) strb_run <= strb_run + 1;
        else           strb_run <= '0;
    end

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pp_astb && pp_dstb));

    p_dir_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb) |-> $past(busy) && $stable(pp_write));

    p_dout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strb && $past(strb) |-> $stable(pp_dout));

    p_strobe_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strb_run <= 32'(LIMIT));

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clear_req));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !strb && !pp_write);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);
endmodule

bind epp_cycle_ctrl epp_cycle_checker #(.DATA_W(DATA_W), .LIMIT(TIMEOUT_CLKS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .host_done  (host_done),
    .pp_astb    (pp_astb),
    .pp_dstb    (pp_dstb),
    .pp_write   (pp_write),
    .pp_dout    (pp_dout),
    .flag       (tmo_flag)
);

// File: tb/test_epp_cycle_ctrl.sv
`timescale 1ns/1ps
module test_epp_cycle_ctrl;
    localparam int LIM = 30;
    localparam int DLY = 2;
    localparam int M_OK = 0, M_HANG = 1, M_STUCK = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [7:0]  ctrl = 8'h00, status_in = 8'hA6;
    logic [31:0] host_rdata;
    logic        host_done, busy;
    logic [7:0]  pp_dout, pp_din = 8'h00;
    logic        pp_write, pp_astb, pp_dstb;
    logic        pp_wait = 1'b0;

    int total = 0, bad = 0;
    int mode = M_OK;
    int log_n = 0;
    logic [7:0] log_byte [0:15];
    logic       log_addr [0:15];
    logic       log_wr   [0:15];
    logic [7:0] src      [0:3];
    logic [31:0] rd;
    bit finished = 0;

    always #10 clk = ~clk;

    epp_cycle_ctrl #(.DATA_W(32), .TIMEOUT_CLKS(LIM)) i_epp_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .ctrl(ctrl), .status_in(status_in), .host_rdata(host_rdata),
        .host_done(host_done), .busy(busy), .pp_dout(pp_dout), .pp_din(pp_din),
        .pp_write(pp_write), .pp_astb(pp_astb), .pp_dstb(pp_dstb), .pp_wait(pp_wait)
    );

    // peripheral model
    initial begin
        logic prev;
        int   cnt;
        prev = 1'b0;
        cnt  = 0;
        forever begin
            @(negedge clk);
            if ((pp_astb || pp_dstb) && !prev) begin
                if (log_n < 16) begin
                    log_byte[log_n] = pp_dout;
                    log_addr[log_n] = pp_astb;
                    log_wr[log_n]   = pp_write;
                end
                log_n++;
                cnt = 0;
            end
            if (pp_astb || pp_dstb) begin
                if (!pp_wait && mode != M_HANG) begin
                    cnt++;
                    if (cnt >= DLY) begin
                        pp_din  = src[(log_n - 1) % 4];
                        pp_wait = 1'b1;
                        cnt     = 0;
                    end
                end
            end else if (pp_wait && mode != M_STUCK) begin
                cnt++;
                if (cnt >= DLY) begin
                    pp_wait = 1'b0;
                    cnt     = 0;
                end
            end
            prev = pp_astb || pp_dstb;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start(input logic wr, input logic [2:0] a, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic wait_done(output logic [31:0] r);
        int n = 0;
        while (!host_done && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk("R9 done seen", {31'd0, host_done}, 32'd1);
        r = host_rdata;
        @(negedge clk);
        chk("R9 done one clock", {31'd0, host_done}, 32'd0);
    endtask

    task automatic access(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] r);
        start(wr, a, sz, wd);
        wait_done(r);
    endtask

    task automatic prep(input int m);
        @(negedge clk);
        mode = m; pp_wait = 1'b0; log_n = 0;
    endtask

    task automatic t_reset();
        chk("R8 busy", {31'd0, busy}, 32'd0);
        chk("R8 done", {31'd0, host_done}, 32'd0);
        chk("R8 strobes/dir", {29'd0, pp_astb, pp_dstb, pp_write}, 32'd0);
        access(1'b0, 3'd1, 2'd0, 32'd0, rd);
        chk("R7 R8 status read flag clear", rd, 32'h0000_00A6);
    endtask

    task automatic t_addr_write();
        prep(M_OK);
        ctrl = 8'h04;
        access(1'b1, 3'd3, 2'd2, 32'hDEAD_BE5A, rd);
        chk("R1 R4 addr write one byte", 32'(log_n), 32'd1);
        chk("R3 addr strobe used", {31'd0, log_addr[0]}, 32'd1);
        chk("R3 direction write", {31'd0, log_wr[0]}, 32'd1);
        chk("R4 addr byte", {24'd0, log_byte[0]}, 32'h5A);
    endtask

    task automatic t_data_write4();
        prep(M_OK);
        ctrl = 8'hC4;
        access(1'b1, 3'd4, 2'd2, 32'h4433_2211, rd);
        chk("R4 four byte cycles", 32'(log_n), 32'd4);
        chk("R4 little-endian order", {log_byte[3], log_byte[2], log_byte[1], log_byte[0]}, 32'h4433_2211);
        chk("R3 data strobe used", {31'd0, log_addr[2]}, 32'd0);
    endtask

    task automatic t_data_read2();
        prep(M_OK);
        src[0] = 8'hBE; src[1] = 8'hEF; src[2] = 8'h12; src[3] = 8'h34;
        ctrl = 8'h24;
        access(1'b0, 3'd4, 2'd1, 32'd0, rd);
        chk("R2 R4 read two bytes", 32'(log_n), 32'd2);
        chk("R4 read assembly", rd, 32'h0000_EFBE);
        chk("R3 direction read", {31'd0, log_wr[0]}, 32'd0);
    endtask

    task automatic t_gated();
        prep(M_OK);
        ctrl = 8'h0C;
        access(1'b1, 3'd4, 2'd0, 32'h55, rd);
        ctrl = 8'h24;
        access(1'b1, 3'd3, 2'd0, 32'h55, rd);
        chk("R1 gated writes no strobe", 32'(log_n), 32'd0);
        ctrl = 8'h04;
        access(1'b0, 3'd4, 2'd2, 32'd0, rd);
        chk("R2 gated read 4B ones", rd, 32'hFFFF_FFFF);
        ctrl = 8'h25;
        access(1'b0, 3'd4, 2'd0, 32'd0, rd);
        chk("R2 gated read 1B ones", rd, 32'h0000_00FF);
        chk("R2 gated reads no strobe", 32'(log_n), 32'd0);
        access(1'b0, 3'd1, 2'd0, 32'd0, rd);
        chk("R1 gated no flag", rd, 32'h0000_00A6);
    endtask

    task automatic t_timeout_write();
        prep(M_HANG);
        ctrl = 8'h04;
        access(1'b1, 3'd4, 2'd2, 32'h0403_0201, rd);
        chk("R5 bytes skipped after abort", 32'(log_n), 32'd1);
        chk("R5 strobe released", {30'd0, pp_astb, pp_dstb}, 32'd0);
        access(1'b0, 3'd1, 2'd0, 32'd0, rd);
        chk("R5 R7 flag in status", rd, 32'h0000_00A7);
    endtask

    task automatic t_sticky();
        access(1'b1, 3'd1, 2'd0, 32'hFE, rd);
        access(1'b0, 3'd1, 2'd0, 32'd0, rd);
        chk("R6 write bit0=0 keeps flag", rd[0], 1'b1);
        access(1'b1, 3'd1, 2'd0, 32'h01, rd);
        access(1'b0, 3'd1, 2'd0, 32'd0, rd);
        chk("R6 write bit0=1 clears flag", rd[0], 1'b0);
    endtask

    task automatic t_stuck_read();
        prep(M_STUCK);
        src[0] = 8'h3C;
        ctrl = 8'h24;
        access(1'b0, 3'd4, 2'd2, 32'd0, rd);
        chk("R5 release-phase abort one byte", 32'(log_n), 32'd1);
        chk("R10 missing lanes read ones", rd, 32'hFFFF_FF3C);
        prep(M_OK);
        access(1'b0, 3'd1, 2'd0, 32'd0, rd);
        chk("R5 flag after release abort", rd[0], 1'b1);
    endtask

    task automatic t_busy();
        prep(M_OK);
        ctrl = 8'h04;
        start(1'b1, 3'd4, 2'd2, 32'hA1B2_C3D4);
        chk("R9 busy after accept", {31'd0, busy}, 32'd1);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 3'd1; host_wdata = 32'h1;
        @(negedge clk);
        host_req = 1'b0;
        wait_done(rd);
        chk("R9 transfer complete", 32'(log_n), 32'd4);
        access(1'b0, 3'd1, 2'd0, 32'd0, rd);
        chk("R9 request while busy ignored", rd[0], 1'b1);
        access(1'b1, 3'd1, 2'd0, 32'h1, rd);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_write();
        t_data_write4();
        t_data_read2();
        t_gated();
        t_timeout_write();
        t_sticky();
        t_stuck_read();
        t_busy();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule